// File: doc/BRIEF.md
# PCI Single-Dword Write Target

This block sits on the target side of a 32-bit PCI bus and accepts exactly one 32-bit write per transaction into a device register space. In the address phase it captures the address and the bus command. The command is then decoded against two programmable base values, one for the I/O write command and one for the memory write command. The upper 24 address bits select the device. The lower 8 bits pass through as the register offset.

On a claim the block asserts DEVSEL# with fixed medium timing and waits for the initiator to be ready. It then completes one data phase with TRDY# and hands the address, data and address space to the device logic through a one-cycle write strobe. If the initiator tries to burst, the first dword is still taken and STOP# forces a disconnect.

Each target control line is presented as a driven value plus an output enable. The pad logic outside the block turns each pair into a tri-state signal. A cleared enable means the line is released to high impedance.

Top module: `pci_wr_target`

## Requirements
- R1: An address phase is recognised when FRAME# is sampled low after being sampled high while the block is idle. Command 4'b0011 on C/BE# is an I/O write and is compared against the I/O base on AD[31:8]. Command 4'b0111 is a memory write and is compared against the memory base on AD[31:8]. The base inputs are used as they stand at the decode, so a changed base takes effect on the next transaction.
- R2: Any other command, or an address whose upper 24 bits differ from the base for its command, is ignored. All three enables (devsel_oe, trdy_oe, stop_oe) stay low and wr_stb never pulses.
- R3: The address phase is cycle 0. On a claim, DEVSEL# is driven low from cycle 2 and stays low up to and including the cycle in which TRDY# is low.
- R4: IRDY# is first sampled at the end of cycle 4, the second cycle after DEVSEL# goes low. TRDY# goes low in the cycle after the first sample of IRDY# low. Until then TRDY# is driven high, from cycle 2 on.
- R5: AD is latched on the clock edge that ends the TRDY# low cycle. In the next cycle wr_stb is high for exactly one cycle, with wr_addr set to the captured address, wr_data set to the latched word, and wr_space set to 0 for I/O or 1 for memory.
- R6: In the cycle after TRDY# is low, TRDY# is driven high and is released in the cycle after that. In a non-burst transaction, DEVSEL# is also driven high in that same cycle and released after it. STOP# is never enabled in a non-burst transaction.
- R7: If FRAME# is still low when IRDY# is first sampled low, this is a burst attempt. STOP# is driven low in the same cycle as TRDY#, and the first dword is still delivered as in R5.
- R8: STOP# and DEVSEL# stay low until FRAME# is sampled high. Both are then driven high for one cycle and released.
- R9: The byte enables on C/BE# during the data phase are ignored: all 32 bits of AD are always delivered.
- R10: While rst_n is low, all three enables and wr_stb are low. A reset during a transaction returns the block to idle at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | FRAME# from the bus |
| irdy_n | input | 1 | IRDY# from the bus |
| ad | input | 32 | AD bus, address then data |
| cbe_n | input | 4 | C/BE#: command in address phase, byte enables in data phase |
| io_base | input | 24 | Base compared with AD[31:8] for I/O writes |
| mem_base | input | 24 | Base compared with AD[31:8] for memory writes |
| devsel_n | output | 1 | DEVSEL# drive value |
| devsel_oe | output | 1 | DEVSEL# output enable |
| trdy_n | output | 1 | TRDY# drive value |
| trdy_oe | output | 1 | TRDY# output enable |
| stop_n | output | 1 | STOP# drive value |
| stop_oe | output | 1 | STOP# output enable |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 32 | Captured write address |
| wr_data | output | 32 | Latched write data |
| wr_space | output | 1 | 0 = I/O space, 1 = memory space |

## Verification
The bench sends a read command to an I/O address and a memory command to an I/O address. A decoder that checked only the address, or mixed up the two bases, would claim these cycles and pulse a write. It holds IRDY# off for several cycles. A design that sampled IRDY# only once, or at the wrong cycle, would assert TRDY# early or hang. Burst attempts hold FRAME# low past the data phase: a design that released STOP# early, or dropped the first dword, would show STOP# gone while FRAME# is still low, or a missing strobe. Odd byte enables in the data phase, a base change, and a reset in mid-transaction expose partial-word writes, stale decode, and a block that stays stuck on the bus.

// File: rtl/pci_wr_pkg.sv
package pci_wr_pkg;

  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic {
    SPC_IO  = 1'b0,
    SPC_MEM = 1'b1
  } space_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DECODE,
    ST_CLAIM,
    ST_WAIT,
    ST_SAMPLE,
    ST_XFER,
    ST_TRDYOFF,
    ST_HOLD,
    ST_END
  } tgt_state_e;

endpackage

// File: rtl/pci_wr_decode.sv
module pci_wr_decode
  import pci_wr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BASE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [ADDR_W-1:0] ad,
  input  logic [3:0]        cbe_n,
  input  logic [BASE_W-1:0] io_base,
  input  logic [BASE_W-1:0] mem_base,
  input  logic              idle,
  output logic              addr_start,
  output logic              dec_hit,
  output logic              dec_miss,
  output logic [ADDR_W-1:0] addr_q,
  output space_e            space_q
);

  localparam int TOP = ADDR_W - 1;

  logic       frame_q;
  logic       valid_q;
  logic [3:0] cmd_q;
  logic       is_io;
  logic       is_mem;
  logic       hit_c;

  function automatic logic base_match(input logic [ADDR_W-1:0] a,
                                      input logic [BASE_W-1:0] b);
    return a[TOP -: BASE_W] == b;
  endfunction

  assign addr_start = idle && !frame_n && frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b1;
      valid_q <= 1'b0;
      cmd_q   <= 4'hF;
      addr_q  <= '0;
    end else begin
      frame_q <= frame_n;
      valid_q <= addr_start;
      if (addr_start) begin
        cmd_q  <= cbe_n;
        addr_q <= ad;
      end
    end
  end

  assign is_io   = (cmd_q == CMD_IO_WR);
  assign is_mem  = (cmd_q == CMD_MEM_WR);
  assign hit_c   = (is_io && base_match(addr_q, io_base)) ||
                   (is_mem && base_match(addr_q, mem_base));
  assign dec_hit  = valid_q && hit_c;
  assign dec_miss = valid_q && !hit_c;
  assign space_q  = is_mem ? SPC_MEM : SPC_IO;

  // R1: every recognised address phase gets a verdict in the next cycle
  assert_verdict_follows_start_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
    addr_start |=> (dec_hit || dec_miss)
  ) else $error("decode verdict missing after address phase");

endmodule

// File: rtl/pci_wr_fsm.sv
module pci_wr_fsm
  import pci_wr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic addr_start,
  input  logic dec_hit,
  input  logic dec_miss,
  output logic idle,
  output logic lat_en,
  output logic devsel_n,
  output logic devsel_oe,
  output logic trdy_n,
  output logic trdy_oe,
  output logic stop_n,
  output logic stop_oe
);

  tgt_state_e state, state_nx;
  logic       burst_q;
  logic       devsel_act;
  logic       trdy_act;
  logic       stop_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      burst_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_DECODE)
        burst_q <= 1'b0;
      else if (state == ST_SAMPLE && !irdy_n)
        burst_q <= !frame_n;
    end
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:    if (addr_start) state_nx = ST_DECODE;
      ST_DECODE:  state_nx = dec_hit ? ST_CLAIM : ST_IDLE;
      ST_CLAIM:   state_nx = ST_WAIT;
      ST_WAIT:    state_nx = ST_SAMPLE;
      ST_SAMPLE:  if (!irdy_n) state_nx = ST_XFER;
      ST_XFER:    state_nx = ST_TRDYOFF;
      ST_TRDYOFF: begin
        if (!burst_q)    state_nx = ST_IDLE;
        else if (frame_n) state_nx = ST_END;
        else             state_nx = ST_HOLD;
      end
      ST_HOLD:    if (frame_n) state_nx = ST_END;
      ST_END:     state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    devsel_oe = 1'b0;
    devsel_n  = 1'b1;
    trdy_oe   = 1'b0;
    trdy_n    = 1'b1;
    stop_oe   = 1'b0;
    stop_n    = 1'b1;
    case (state)
      ST_CLAIM, ST_WAIT, ST_SAMPLE: begin
        devsel_oe = 1'b1;
        devsel_n  = 1'b0;
        trdy_oe   = 1'b1;
      end
      ST_XFER: begin
        devsel_oe = 1'b1;
        devsel_n  = 1'b0;
        trdy_oe   = 1'b1;
        trdy_n    = 1'b0;
        stop_oe   = burst_q;
        stop_n    = !burst_q;
      end
      ST_TRDYOFF: begin
        devsel_oe = 1'b1;
        devsel_n  = !burst_q;
        trdy_oe   = 1'b1;
        stop_oe   = burst_q;
        stop_n    = !burst_q;
      end
      ST_HOLD: begin
        devsel_oe = 1'b1;
        devsel_n  = 1'b0;
        stop_oe   = 1'b1;
        stop_n    = 1'b0;
      end
      ST_END: begin
        devsel_oe = 1'b1;
        stop_oe   = 1'b1;
      end
      default: ;
    endcase
  end

  assign idle   = (state == ST_IDLE);
  assign lat_en = (state == ST_XFER);

  assign devsel_act = devsel_oe && !devsel_n;
  assign trdy_act   = trdy_oe && !trdy_n;
  assign stop_act   = stop_oe && !stop_n;

  // R2: a rejected address phase leaves the bus untouched
  assert_miss_stays_quiet_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    dec_miss |=> !(devsel_oe || trdy_oe || stop_oe)
  ) else $error("target drove the bus after a decode miss");

  // R3: claim shows as DEVSEL# low right after the decode cycle
  assert_devsel_after_hit_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    dec_hit |=> devsel_act
  ) else $error("DEVSEL# not asserted in cycle 2");

  // R6: TRDY# is driven high for one cycle after the data phase
  assert_trdy_drive_high_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    $fell(trdy_act) |-> (trdy_oe && trdy_n)
  ) else $error("TRDY# released without a high cycle");

  assert_trdy_release_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    $fell(trdy_act) |=> !trdy_oe
  ) else $error("TRDY# still driven two cycles after data phase");

  // R7: STOP# never appears without TRDY# in its first cycle
  assert_stop_with_trdy_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(stop_act) |-> trdy_act
  ) else $error("STOP# asserted apart from TRDY#");

  // R8: STOP# holds while FRAME# is low
  assert_stop_hold_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (stop_act && !frame_n) |=> stop_act
  ) else $error("STOP# dropped while FRAME# still low");

endmodule

// File: rtl/pci_wr_datapath.sv
module pci_wr_datapath
  import pci_wr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lat_en,
  input  logic [DATA_W-1:0] ad,
  input  logic [ADDR_W-1:0] addr_q,
  input  space_e            space_q,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_space
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_space <= 1'b0;
    end else begin
      wr_stb <= lat_en;
      if (lat_en) begin
        wr_addr  <= addr_q;
        wr_data  <= ad;
        wr_space <= (space_q == SPC_MEM);
      end
    end
  end

  // R5: the write strobe lasts one cycle per dword
  assert_stb_single_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb
  ) else $error("write strobe longer than one cycle");

endmodule

// File: rtl/pci_wr_target.sv
module pci_wr_target
  import pci_wr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BASE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [ADDR_W-1:0] ad,
  input  logic [3:0]        cbe_n,
  input  logic [BASE_W-1:0] io_base,
  input  logic [BASE_W-1:0] mem_base,
  output logic              devsel_n,
  output logic              devsel_oe,
  output logic              trdy_n,
  output logic              trdy_oe,
  output logic              stop_n,
  output logic              stop_oe,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] wr_data,
  output logic              wr_space
);

  localparam int DATA_W = ADDR_W;

  logic              idle;
  logic              addr_start;
  logic              dec_hit;
  logic              dec_miss;
  logic              lat_en;
  logic [ADDR_W-1:0] addr_q;
  space_e            space_q;
  logic              trdy_act;

  pci_wr_decode #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .ad         (ad),
    .cbe_n      (cbe_n),
    .io_base    (io_base),
    .mem_base   (mem_base),
    .idle       (idle),
    .addr_start (addr_start),
    .dec_hit    (dec_hit),
    .dec_miss   (dec_miss),
    .addr_q     (addr_q),
    .space_q    (space_q)
  );

  pci_wr_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .addr_start (addr_start),
    .dec_hit    (dec_hit),
    .dec_miss   (dec_miss),
    .idle       (idle),
    .lat_en     (lat_en),
    .devsel_n   (devsel_n),
    .devsel_oe  (devsel_oe),
    .trdy_n     (trdy_n),
    .trdy_oe    (trdy_oe),
    .stop_n     (stop_n),
    .stop_oe    (stop_oe)
  );

  pci_wr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .lat_en   (lat_en),
    .ad       (ad),
    .addr_q   (addr_q),
    .space_q  (space_q),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_space (wr_space)
  );

  assign trdy_act = trdy_oe && !trdy_n;

  // R4: TRDY# only goes low after IRDY# was seen low
  assert_trdy_needs_irdy_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(trdy_act) |-> $past(!irdy_n)
  ) else $error("TRDY# asserted without a ready initiator");

  // R5: a write reaches the device only after a completed data phase
  assert_stb_after_xfer_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(trdy_act && !irdy_n)
  ) else $error("write strobe without a data phase");

endmodule

// File: tb/pci_wr_target_test.sv
module pci_wr_target_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic [23:0] io_base = 24'h00C010;
  logic [23:0] mem_base = 24'hFEB000;
  logic        devsel_n, devsel_oe, trdy_n, trdy_oe, stop_n, stop_oe;
  logic        wr_stb, wr_space;
  logic [31:0] wr_addr, wr_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pci_wr_target uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .ad(ad), .cbe_n(cbe_n), .io_base(io_base), .mem_base(mem_base),
    .devsel_n(devsel_n), .devsel_oe(devsel_oe), .trdy_n(trdy_n),
    .trdy_oe(trdy_oe), .stop_n(stop_n), .stop_oe(stop_oe),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_space(wr_space)
  );

  localparam int NV = 9;
  localparam logic [31:0] VA [NV] = '{32'hFEB00004, 32'h00C01008, 32'hFEB000FC,
                                      32'hFEB00010, 32'h00C01020, 32'h00C01004,
                                      32'h00C01004, 32'hFEB00104, 32'hFEB00008};
  localparam logic [3:0]  VC [NV] = '{4'b0111, 4'b0011, 4'b0111, 4'b0111, 4'b0011,
                                      4'b0111, 4'b0010, 4'b0111, 4'b1011};
  localparam logic [31:0] VD [NV] = '{32'hA5A50001, 32'h12345678, 32'hDEADBEEF,
                                      32'h0BADF00D, 32'hCAFE0042, 32'h11111111,
                                      32'h22222222, 32'h33333333, 32'h44444444};
  localparam logic [3:0]  VB [NV] = '{4'h0, 4'hE, 4'h0, 4'h5, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0};
  localparam int          VW [NV] = '{0, 0, 6, 0, 5, 0, 0, 2, 0};
  localparam bit          VS [NV] = '{0, 0, 0, 1, 1, 0, 0, 0, 0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [31:0] a, input logic [3:0] c);
    return (c == 4'b0011 && a[31:8] == io_base) || (c == 4'b0111 && a[31:8] == mem_base);
  endfunction

  function automatic logic [31:0] oes();
    return {29'd0, devsel_oe, trdy_oe, stop_oe};
  endfunction

  task automatic run_txn(input logic [31:0] a, input logic [3:0] cmd,
                         input logic [31:0] d, input logic [3:0] be,
                         input int dly, input bit bst);
    bit hit;
    int k, t, last_out;
    hit = exp_hit(a, cmd);
    k = 1 + dly;
    t = ((k > 4) ? k : 4) + 1;
    last_out = bst ? t + 3 : t + 1;
    @(negedge clk);
    frame_n = 1'b0; ad = a; cbe_n = cmd; irdy_n = 1'b1;
    for (int c = 1; c <= t + 6; c++) begin
      @(negedge clk);
      if (!hit) begin
        chk("R2 bus enables on miss", oes(), 32'd0);
        chk("R2 strobe on miss", {31'd0, wr_stb}, 32'd0);
      end else begin
        if (c == 1) chk("R3 devsel released in cycle 1", {31'd0, devsel_oe}, 32'd0);
        if (c == 2) chk("R3 devsel low in cycle 2", {31'd0, devsel_oe && !devsel_n}, 32'd1);
        if (c == t - 1) chk("R4 trdy driven high while waiting", {31'd0, trdy_oe && trdy_n}, 32'd1);
        if (c == t) begin
          chk("R4 trdy low after irdy sample", {31'd0, trdy_oe && !trdy_n}, 32'd1);
          chk("R3 devsel low in data phase", {31'd0, devsel_oe && !devsel_n}, 32'd1);
          chk("R7 stop with trdy", {31'd0, stop_oe && !stop_n}, {31'd0, bst});
        end
        if (c == t + 1) begin
          chk("R5 strobe", {31'd0, wr_stb}, 32'd1);
          chk("R5 address", wr_addr, a);
          chk("R9 full dword data", wr_data, d);
          chk("R5 space", {31'd0, wr_space}, {31'd0, cmd == 4'b0111});
          chk("R6 trdy driven high", {31'd0, trdy_oe && trdy_n}, 32'd1);
          if (!bst) chk("R6 devsel driven high", {31'd0, devsel_oe && devsel_n}, 32'd1);
          else      chk("R7 stop held", {31'd0, stop_oe && !stop_n}, 32'd1);
        end else begin
          chk("R5 strobe only once", {31'd0, wr_stb}, 32'd0);
        end
        if (c == t + 2) begin
          chk("R6 trdy released", {31'd0, trdy_oe}, 32'd0);
          if (!bst) chk("R6 devsel/stop released", {30'd0, devsel_oe, stop_oe}, 32'd0);
          else      chk("R8 stop held while frame low", {31'd0, stop_oe && !stop_n}, 32'd1);
        end
        if (bst && c == t + 3)
          chk("R8 devsel/stop driven high", {30'd0, devsel_oe && devsel_n, stop_oe && stop_n}, 32'd3);
        if (c > last_out) chk("R6 R8 bus released after end", oes(), 32'd0);
      end
      if (bst) frame_n = (c >= t + 2);
      else     frame_n = (c >= k);
      irdy_n = !(c >= k && c <= t);
      ad     = (c <= t) ? d : 32'd0;
      cbe_n  = be;
    end
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 enables in reset", oes(), 32'd0);
    chk("R10 strobe in reset", {31'd0, wr_stb}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_txn(VA[i], VC[i], VD[i], VB[i], VW[i], VS[i]);

    // R1: base changes take effect on the next transaction
    mem_base = 24'h80_0001;
    run_txn(32'hFEB00004, 4'b0111, 32'h55555555, 4'h0, 0, 0);
    run_txn(32'h80000140, 4'b0111, 32'h66666666, 4'h0, 1, 0);

    // R10: reset in the middle of a claimed transaction
    @(negedge clk);
    frame_n = 1'b0; ad = 32'h00C01010; cbe_n = 4'b0011;
    @(negedge clk);
    ad = 32'h77777777; cbe_n = 4'h0; irdy_n = 1'b0; frame_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R3 devsel low before reset", {31'd0, devsel_oe && !devsel_n}, 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R10 enables cleared by reset", oes(), 32'd0);
    @(negedge clk);
    irdy_n = 1'b1; rst_n = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk("R10 quiet after reset", {30'd0, |oes(), wr_stb}, 32'd0);
    end
    run_txn(32'h00C01018, 4'b0011, 32'h88888888, 4'h3, 3, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule